// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block lays a 32×32 pointer image over a live pixel stream. Each pixel of the image carries a 2-bit code. The code selects one of three programmable colours, lets the underlying pixel through, or inverts it. A single mode bit decides between inversion and a third, auxiliary colour for one of the four codes.

The image is anchored by a hot spot, which is a point inside the bitmap. A screen position places that hot spot. All coordinates are in input-resolution pixels, with (0,0) at the top-left. The cursor can hang off the right and bottom edges of the screen, and the part outside is then cut away. The hot spot is never placed left of or above the screen origin. The bitmap can be loaded through a byte-wide register write port. It can also be loaded from an in-band byte stream, where it follows a block of lookup-table bytes that this block skips.

Each incoming pixel gives its own screen coordinates together with its RGB value. The overlaid pixel appears one clock later.

Top module: `cursor_overlay`

## Requirements
- R1: After reset `out_valid` is 0, `out_rgb` is 0 and the control register is cleared. While the enable bit (control bit 0) is 0, every output pixel equals its input pixel.
- R2: `out_valid` equals `pix_valid` delayed by exactly one clock. `out_rgb` is the overlay result for the pixel that was presented one clock earlier.
- R3: With the effective screen position (PX,PY) and hot spot (HX,HY), pixel (x,y) is under the cursor exactly when 0 ≤ x−PX+HX ≤ 31 and 0 ≤ y−PY+HY ≤ 31. A pixel outside that window passes unchanged.
- R4: Code 00 outputs the second colour and code 01 outputs the first colour. Colours are packed R in bits 23:16, G in 15:8 and B in 7:0.
- R5: Code 10 is transparent: the input pixel is output unchanged.
- R6: Code 11 with the mode bit (control bit 1) at 0 outputs the bitwise complement of each 8-bit component of the input.
- R7: Code 11 with the mode bit at 1 outputs the auxiliary colour.
- R8: Bitmap pixel (column c, row r) is read from byte r·8 + c/4, bits 2·(c mod 4)+1 : 2·(c mod 4).
- R9: The cursor is clipped at the right and bottom borders. A cursor placed near the maximum coordinate never wraps onto pixels at low coordinates.
- R10: When the screen position on an axis is smaller than the hot spot on that axis, the position used is the hot spot value, so the bitmap origin never lies left of or above screen 0.
- R11: With in-band load enabled (control bit 2), a `upl_start` pulse arms the loader. The following `LUT_BYTES` bytes strobed by `upl_valid` are skipped. The next 256 bytes fill bitmap bytes 0..255 in order, and any later bytes are ignored. With bit 2 clear, `upl_start` arms nothing.
- R12: Write map on `wr_addr`: 0x000–0x0FF bitmap bytes; 0x100 control; 0x101–0x103 first colour R,G,B; 0x104–0x106 second colour; 0x107–0x109 auxiliary colour; 0x10A hot-spot X (bits 4:0); 0x10B hot-spot Y; 0x10C/0x10D screen X low byte/high bits; 0x10E/0x10F screen Y low/high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register/bitmap write strobe |
| wr_addr | input | 9 | Write address |
| wr_data | input | 8 | Write data |
| upl_start | input | 1 | Start marker of the in-band table stream |
| upl_valid | input | 1 | In-band byte strobe |
| upl_byte | input | 8 | In-band byte |
| pix_valid | input | 1 | Input pixel valid |
| pix_x | input | CW | Input pixel column |
| pix_y | input | CW | Input pixel row |
| pix_rgb | input | 24 | Input pixel colour |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Overlaid pixel colour |

## Verification
On every cycle, the assertions check the one-cycle valid pipeline and pass-through while disabled or outside the cursor window. They also check the transparent and inverting codes against the delayed input and the loader's byte counting. The colour selections, the bit packing of the bitmap, and clipping against the border need the bench. So do the clamping of the hot spot against the origin and the correct placement of streamed bytes, because these depend on bitmap contents and register values that only a reference model of the stream can predict.

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int CW        = 12,
  parameter int LUT_BYTES = 768
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [8:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          upl_start,
  input  logic          upl_valid,
  input  logic [7:0]    upl_byte,
  input  logic          pix_valid,
  input  logic [CW-1:0] pix_x,
  input  logic [CW-1:0] pix_y,
  input  logic [23:0]   pix_rgb,
  output logic          out_valid,
  output logic [23:0]   out_rgb
);
  localparam int TOTAL = LUT_BYTES + 256;
  localparam int UPW   = $clog2(TOTAL + 1);
  localparam logic [UPW-1:0] LUTC = UPW'(LUT_BYTES);
  localparam logic [UPW-1:0] LAST = UPW'(TOTAL - 1);

  logic [2:0]    ctl;
  logic [23:0]   c1, c2, caux;
  logic [4:0]    hot_x, hot_y;
  logic [CW-1:0] pos_x, pos_y;
  logic [7:0]    bmp [256];

  logic          ctl_en, ctl_mode, ctl_inb;
  assign ctl_en   = ctl[0];
  assign ctl_mode = ctl[1];
  assign ctl_inb  = ctl[2];

  logic reg_sel;
  assign reg_sel = wr_en && wr_addr[8] && (wr_addr[7:4] == 4'h0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0; c1 <= '0; c2 <= '0; caux <= '0;
      hot_x <= '0; hot_y <= '0; pos_x <= '0; pos_y <= '0;
    end else if (reg_sel) begin
      case (wr_addr[3:0])
        4'h0: ctl <= wr_data[2:0];
        4'h1: c1[23:16]   <= wr_data;
        4'h2: c1[15:8]    <= wr_data;
        4'h3: c1[7:0]     <= wr_data;
        4'h4: c2[23:16]   <= wr_data;
        4'h5: c2[15:8]    <= wr_data;
        4'h6: c2[7:0]     <= wr_data;
        4'h7: caux[23:16] <= wr_data;
        4'h8: caux[15:8]  <= wr_data;
        4'h9: caux[7:0]   <= wr_data;
        4'hA: hot_x <= wr_data[4:0];
        4'hB: hot_y <= wr_data[4:0];
        4'hC: pos_x[7:0]    <= wr_data;
        4'hD: pos_x[CW-1:8] <= wr_data[CW-9:0];
        4'hE: pos_y[7:0]    <= wr_data;
        default: pos_y[CW-1:8] <= wr_data[CW-9:0];
      endcase
    end
  end

  logic           upl_active;
  logic [UPW-1:0] upl_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upl_active <= 1'b0;
      upl_cnt    <= '0;
    end else if (upl_start && ctl_inb) begin
      upl_active <= 1'b1;
      upl_cnt    <= '0;
    end else if (upl_active && upl_valid) begin
      upl_cnt <= upl_cnt + 1'b1;
      if (upl_cnt == LAST) upl_active <= 1'b0;
    end
  end

  logic       upl_we, bm_we;
  logic [7:0] bm_wa, bm_wd;
  assign upl_we = upl_active && upl_valid && (upl_cnt >= LUTC);
  assign bm_we  = (wr_en && !wr_addr[8]) || upl_we;
  assign bm_wa  = (wr_en && !wr_addr[8]) ? wr_addr[7:0] : 8'(upl_cnt - LUTC);
  assign bm_wd  = (wr_en && !wr_addr[8]) ? wr_data : upl_byte;

  always_ff @(posedge clk) begin
    if (bm_we) bmp[bm_wa] <= bm_wd;
  end

  logic [CW-1:0] px_eff, py_eff;
  logic [CW+1:0] dx, dy;
  logic          hit;
  logic [7:0]    cur_byte;
  logic [1:0]    code;

  assign px_eff = (pos_x < CW'(hot_x)) ? CW'(hot_x) : pos_x;
  assign py_eff = (pos_y < CW'(hot_y)) ? CW'(hot_y) : pos_y;
  assign dx  = {2'b00, pix_x} + (CW+2)'(hot_x) - {2'b00, px_eff};
  assign dy  = {2'b00, pix_y} + (CW+2)'(hot_y) - {2'b00, py_eff};
  assign hit = (dx[CW+1:5] == '0) && (dy[CW+1:5] == '0);
  assign cur_byte = bmp[{dy[4:0], dx[4:2]}];
  assign code = cur_byte[{dx[1:0], 1'b0} +: 2];

  logic [23:0] mix;
  always_comb begin
    mix = pix_rgb;
    if (ctl_en && hit) begin
      case (code)
        2'b00:   mix = c2;
        2'b01:   mix = c1;
        2'b10:   mix = pix_rgb;
        default: mix = ctl_mode ? caux : ~pix_rgb;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= pix_valid;
      if (pix_valid) out_rgb <= mix;
    end
  end
endmodule

module cursor_overlay_chk #(
  parameter int UPW = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pix_valid,
  input logic [23:0]    pix_rgb,
  input logic           out_valid,
  input logic [23:0]    out_rgb,
  input logic           en,
  input logic           mode,
  input logic           hit,
  input logic [1:0]     code,
  input logic           upl_active,
  input logic           upl_valid,
  input logic [UPW-1:0] upl_cnt
);
  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);
  assert_disabled_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !en) |=> out_rgb == $past(pix_rgb));
  assert_outside_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !hit) |=> out_rgb == $past(pix_rgb));
  assert_transparent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && hit && code == 2'b10) |=> out_rgb == $past(pix_rgb));
  assert_invert_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && en && hit && code == 2'b11 && !mode) |=> out_rgb == ~$past(pix_rgb));
  assert_loader_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (upl_active && upl_valid) |=> (upl_cnt == $past(upl_cnt) + 1'b1) || !upl_active || upl_cnt == '0);
endmodule

bind cursor_overlay cursor_overlay_chk #(.UPW(UPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_rgb(pix_rgb),
  .out_valid(out_valid), .out_rgb(out_rgb), .en(ctl_en), .mode(ctl_mode),
  .hit(hit), .code(code), .upl_active(upl_active), .upl_valid(upl_valid),
  .upl_cnt(upl_cnt)
);

// File: tb/tb_cursor_overlay.sv
module tb_cursor_overlay;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int LUT_BYTES = 768;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0; logic [8:0] wr_addr = '0; logic [7:0] wr_data = '0;
  logic upl_start = 0, upl_valid = 0; logic [7:0] upl_byte = '0;
  logic pix_valid = 0; logic [CW-1:0] pix_x = '0, pix_y = '0; logic [23:0] pix_rgb = '0;
  logic out_valid; logic [23:0] out_rgb;

  cursor_overlay #(.CW(CW), .LUT_BYTES(LUT_BYTES)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_bm [256];
  logic [2:0] m_ctl = 0;
  logic [23:0] m_c1 = 0, m_c2 = 0, m_aux = 0;
  int m_hx = 0, m_hy = 0, m_px = 0, m_py = 0;
  string exp_tag;

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] model(int x, int y, logic [23:0] rgb);
    int px, py, dx, dy, code;
    exp_tag = "R1";
    if (!m_ctl[0]) return rgb;
    px = (m_px < m_hx) ? m_hx : m_px;
    py = (m_py < m_hy) ? m_hy : m_py;
    dx = x - px + m_hx; dy = y - py + m_hy;
    exp_tag = "R3";
    if (dx < 0 || dx > 31 || dy < 0 || dy > 31) return rgb;
    code = (m_bm[dy*8 + dx/4] >> (2*(dx%4))) & 3;
    case (code)
      0: begin exp_tag = "R4"; return m_c2; end
      1: begin exp_tag = "R4"; return m_c1; end
      2: begin exp_tag = "R5"; return rgb; end
      default: begin
        if (m_ctl[1]) begin exp_tag = "R7"; return m_aux; end
        exp_tag = "R6"; return ~rgb;
      end
    endcase
  endfunction

  task automatic wr(int a, logic [7:0] d);
    wr_en = 1; wr_addr = 9'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
    if (a < 256) m_bm[a] = d;
    else case (a)
      'h100: m_ctl = d[2:0];
      'h101: m_c1[23:16] = d; 'h102: m_c1[15:8] = d; 'h103: m_c1[7:0] = d;
      'h104: m_c2[23:16] = d; 'h105: m_c2[15:8] = d; 'h106: m_c2[7:0] = d;
      'h107: m_aux[23:16] = d; 'h108: m_aux[15:8] = d; 'h109: m_aux[7:0] = d;
      'h10A: m_hx = d[4:0]; 'h10B: m_hy = d[4:0];
      'h10C: m_px = (m_px & 'hF00) | d; 'h10D: m_px = (m_px & 'hFF) | ((d & 'hF) << 8);
      'h10E: m_py = (m_py & 'hF00) | d; 'h10F: m_py = (m_py & 'hFF) | ((d & 'hF) << 8);
      default: ;
    endcase
  endtask

  task automatic set_pos(int px, int py, int hx, int hy);
    wr('h10A, 8'(hx)); wr('h10B, 8'(hy));
    wr('h10C, 8'(px)); wr('h10D, 8'(px >> 8));
    wr('h10E, 8'(py)); wr('h10F, 8'(py >> 8));
  endtask

  task automatic pix(int x, int y, logic [23:0] rgb, string force_tag = "");
    logic [23:0] e;
    e = model(x, y, rgb);
    if (force_tag != "") exp_tag = force_tag;
    pix_valid = 1; pix_x = CW'(x); pix_y = CW'(y); pix_rgb = rgb;
    @(negedge clk);
    pix_valid = 0;
    check("R2", {23'd0, out_valid}, 24'd1);
    check(exp_tag, out_rgb, e);
  endtask

  task automatic stream(bit armed, int extra, logic [7:0] seedb);
    upl_start = 1; @(negedge clk); upl_start = 0;
    for (int i = 0; i < LUT_BYTES + 256 + extra; i++) begin
      logic [7:0] b;
      b = (i < LUT_BYTES) ? 8'hEE : 8'($urandom) ^ seedb;
      upl_valid = 1; upl_byte = b;
      @(negedge clk);
      if (armed && i >= LUT_BYTES && i < LUT_BYTES + 256) m_bm[i - LUT_BYTES] = b;
    end
    upl_valid = 0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) m_bm[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1", {23'd0, out_valid}, 24'd0);
    check("R1", out_rgb, 24'd0);
    rst_n = 1;
    @(negedge clk);
    pix(10, 10, 24'h123456, "R1");

    wr('h101, 8'h11); wr('h102, 8'h22); wr('h103, 8'h33);
    wr('h104, 8'h44); wr('h105, 8'h55); wr('h106, 8'h66);
    wr('h107, 8'h77); wr('h108, 8'h88); wr('h109, 8'h99);
    for (int i = 0; i < 256; i++) wr(i, 8'($urandom));
    set_pos(100, 50, 5, 7);
    pix(100, 50, 24'hABCDEF, "R1");
    wr('h100, 8'h01);

    // R8: byte 9 = row 1, columns 4..7 with codes 00,01,10,11
    wr(9, 8'b11_10_01_00);
    pix(99, 44, 24'h0F0F0F, "R8");
    pix(100, 44, 24'h0F0F0F, "R8");
    pix(101, 44, 24'h0F0F0F, "R8");
    pix(102, 44, 24'h0F0F0F, "R8");
    // R3 window edges
    pix(94, 50, 24'h010203); pix(95, 50, 24'h010203);
    pix(126, 50, 24'h010203); pix(127, 50, 24'h010203);
    pix(100, 42, 24'h010203); pix(100, 43, 24'h010203);
    pix(100, 74, 24'h010203); pix(100, 75, 24'h010203);

    for (int i = 0; i < 400; i++)
      pix(90 + int'($urandom_range(0, 45)), 40 + int'($urandom_range(0, 40)), 24'($urandom));
    wr('h100, 8'h03);
    pix(102, 44, 24'h0F0F0F, "R7");
    for (int i = 0; i < 400; i++)
      pix(90 + int'($urandom_range(0, 45)), 40 + int'($urandom_range(0, 40)), 24'($urandom));
    wr('h100, 8'h01);

    // R9 clipping near the far corner
    wr(0, 8'h01);
    set_pos(4095, 4095, 0, 0);
    pix(4095, 4095, 24'h202020, "R9");
    pix(0, 4095, 24'h202020, "R9");
    pix(4095, 0, 24'h202020, "R9");
    pix(0, 0, 24'h202020, "R9");
    // R10 clamp against origin
    set_pos(2, 3, 10, 12);
    pix(0, 0, 24'h303030, "R10");
    pix(2, 3, 24'h303030, "R10");
    for (int i = 0; i < 60; i++)
      pix(int'($urandom_range(0, 40)), int'($urandom_range(0, 40)), 24'($urandom), "R10");

    // R11 in-band load
    set_pos(100, 50, 5, 7);
    wr('h100, 8'h05);
    stream(1'b1, 4, 8'h00);
    for (int r = 0; r < 32; r++)
      for (int c = 0; c < 32; c++) pix(95 + c, 43 + r, 24'($urandom), "R11");
    wr('h100, 8'h01);
    stream(1'b0, 0, 8'h5A);
    for (int i = 0; i < 80; i++)
      pix(95 + int'($urandom_range(0, 31)), 43 + int'($urandom_range(0, 31)), 24'($urandom), "R11");

    // R1 disable inside cursor
    wr('h100, 8'h00);
    for (int i = 0; i < 20; i++)
      pix(95 + int'($urandom_range(0, 31)), 43 + int'($urandom_range(0, 31)), 24'($urandom), "R1");
    // R12 colour lane placement
    wr('h100, 8'h01);
    wr(0, 8'h00); wr('h105, 8'hC3);
    pix(95, 43, 24'h000000, "R12");
    finish_run();
  end
endmodule